// File: doc/BRIEF.md
# Variable-Frequency Phase Accumulator Oscillator

This block is a numerically controlled oscillator clocked by a reference clock. A 16-bit control word, loaded one byte at a time, sets a step size that is added to a 16-bit phase accumulator on every reference-clock cycle while the channel runs. The top bit of the accumulator is a square wave whose average frequency is W × f_ref / 2^16, where W is the step magnitude.

The control word is read as a signed value. A word below 0x8000 is used as the step directly. A word at or above 0x8000 is replaced by its 16-bit two's complement, so the step is 2^16 minus the word. A power-of-two step gives a waveform that is high for exactly half of each period. The useful steps run from 1 to 32768.

Alongside the square wave, the block emits a one-cycle tick on every rising edge of that wave. A downstream constant-frequency PWM uses this tick as its time base. A run control clears the phase while it is low, and the phase restarts from zero when it rises.

Top module: `vf_phase_nco`

## Requirements
- R1: After a synchronous reset, `vf_out` and `vf_tick` are 0 and the stored control word is 0x0000.
- R2: When `cw_wr` is high, `cw_data` is stored in one byte of the control word. `cw_sel` = 1 selects bits 15:8 and `cw_sel` = 0 selects bits 7:0. The other byte keeps its value.
- R3: A control word at or above 0x8000 gives a step of 2^16 minus the word. A word below 0x8000 gives a step equal to the word. For example, 0xC000 behaves like 0x4000.
- R4: While `chan_start` is high, the phase grows by the step on every clock edge, modulo 2^16. `vf_out` is bit 15 of the phase.
- R5: A power-of-two step gives a `vf_out` that is high for exactly half of each period. For example, step 0x1000 gives 8 cycles high and 8 cycles low.
- R6: While `chan_start` is low, the phase is held at zero, so `vf_out` is 0 and `vf_tick` is 0.
- R7: When `chan_start` rises, the phase restarts from zero. With step 0x4000, `vf_out` is still 0 after the first edge with start high, and it is 1 (with a tick) after the second edge.
- R8: A control word of 0 gives no ticks and a `vf_out` that stays low.
- R9: `vf_tick` is high for exactly one cycle each time `vf_out` goes from 0 to 1, in the same cycle that `vf_out` first reads 1. At no other time is it high.
- R10: A byte written at edge k sets the step at edge k+1. That step is first added to the phase at edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_start | input | 1 | Run control; low holds the phase at zero |
| cw_wr | input | 1 | Byte write strobe for the control word |
| cw_sel | input | 1 | Byte lane select: 1 = high byte, 0 = low byte |
| cw_data | input | 8 | Byte written to the selected lane |
| vf_out | output | 1 | Variable-frequency square wave (phase MSB) |
| vf_tick | output | 1 | One-cycle pulse on each rising edge of `vf_out` |

## Verification
A byte write reaches the phase two edges after the edge that captures it, because the word register and the step register lie on the way. A change of `chan_start` shows on `vf_out` and `vf_tick` right after the next edge. The bench keeps a cycle-accurate model that mirrors these registers as requirements. It drives inputs on the falling edge, advances the model at the rising edge, and compares the outputs at the following falling edge. Directed cases count ticks and high cycles over windows that start only after the step has settled. Their expected totals are derived by hand from the step size.

// File: rtl/vf_nco_pkg.sv
package vf_nco_pkg;
  parameter int unsigned CW_W   = 16;
  parameter int unsigned BYTE_W = 8;
  localparam int unsigned LANES = CW_W / BYTE_W;
  localparam int unsigned SEL_W = (LANES > 1) ? $clog2(LANES) : 1;

  typedef logic [CW_W-1:0]   cword_t;
  typedef logic [BYTE_W-1:0] cbyte_t;
endpackage

// File: rtl/vf_cw_bytes.sv
module vf_cw_bytes
  import vf_nco_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [SEL_W-1:0] sel,
  input  cbyte_t           data,
  output cword_t           cword
);
  cword_t cw_q;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk) begin
        if (rst)
          cw_q[g*BYTE_W +: BYTE_W] <= '0;
        else if (wr && (sel == SEL_W'(g)))
          cw_q[g*BYTE_W +: BYTE_W] <= data;
      end
    end
  endgenerate

  assign cword = cw_q;

  // R2: a high-lane write leaves the low lane untouched
  a_r2_low_kept: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_W'(LANES-1)) |=> (cw_q[BYTE_W-1:0] == $past(cw_q[BYTE_W-1:0])));
  // R2: a low-lane write leaves the high lane untouched
  a_r2_high_kept: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == SEL_W'(0)) |=> (cw_q[CW_W-1:CW_W-BYTE_W] == $past(cw_q[CW_W-1:CW_W-BYTE_W])));
endmodule

// File: rtl/vf_step_mag.sv
module vf_step_mag
  import vf_nco_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  cword_t cword,
  output cword_t step
);
  localparam cword_t HALF = cword_t'(1) << (CW_W-1);

  cword_t step_q;

  always_ff @(posedge clk) begin
    if (rst)
      step_q <= '0;
    else if (cword[CW_W-1])
      step_q <= ~cword + cword_t'(1);
    else
      step_q <= cword;
  end

  assign step = step_q;

  // R3: the magnitude never exceeds half the phase range
  a_r3_step_bound: assert property (@(posedge clk) disable iff (rst)
    step_q <= HALF);
endmodule

// File: rtl/vf_phase_acc.sv
module vf_phase_acc
  import vf_nco_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   run,
  input  cword_t step,
  output logic   msb,
  output logic   tick
);
  cword_t acc_q;
  cword_t acc_nxt;
  logic   tick_q;

  always_comb begin
    if (run)
      acc_nxt = acc_q + step;
    else
      acc_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_nxt;
      tick_q <= run & ~acc_q[CW_W-1] & acc_nxt[CW_W-1];
    end
  end

  assign msb  = acc_q[CW_W-1];
  assign tick = tick_q;

  // R6: a cleared run control leaves the phase at zero
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !run |=> (acc_q == '0 && !tick_q));
  // R8: a zero step keeps the phase frozen
  a_r8_zero_step: assert property (@(posedge clk) disable iff (rst)
    (run && step == '0) |=> $stable(acc_q));
endmodule

// File: rtl/vf_phase_nco.sv
module vf_phase_nco
  import vf_nco_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             chan_start,
  input  logic             cw_wr,
  input  logic [SEL_W-1:0] cw_sel,
  input  logic [BYTE_W-1:0] cw_data,
  output logic             vf_out,
  output logic             vf_tick
);
  cword_t cword;
  cword_t step;

  vf_cw_bytes u_bytes (
    .clk   (clk),
    .rst   (rst),
    .wr    (cw_wr),
    .sel   (cw_sel),
    .data  (cw_data),
    .cword (cword)
  );

  vf_step_mag u_mag (
    .clk   (clk),
    .rst   (rst),
    .cword (cword),
    .step  (step)
  );

  vf_phase_acc u_acc (
    .clk  (clk),
    .rst  (rst),
    .run  (chan_start),
    .step (step),
    .msb  (vf_out),
    .tick (vf_tick)
  );

  // R9: a tick marks the first cycle of a high phase
  a_r9_tick_edge: assert property (@(posedge clk) disable iff (rst)
    vf_tick |-> (vf_out && !$past(vf_out)));
  // R9: ticks never last two cycles
  a_r9_tick_single: assert property (@(posedge clk) disable iff (rst)
    vf_tick |=> !vf_tick);
  // R9: every rise of the output carries a tick
  a_r9_rise_ticks: assert property (@(posedge clk) disable iff (rst)
    $rose(vf_out) |-> vf_tick);
endmodule

// File: tb/vf_phase_nco_bench.sv
module vf_phase_nco_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst;
  logic       chan_start;
  logic       cw_wr;
  logic [0:0] cw_sel;
  logic [7:0] cw_data;
  logic       vf_out;
  logic       vf_tick;

  int checks = 0;
  int errors = 0;
  int tick_cnt = 0;
  int high_cnt = 0;
  bit done = 1'b0;

  logic [15:0] m_cw, m_step, m_acc;
  logic        m_out, m_tick;

  always #(CLK_PERIOD/2) clk = ~clk;

  vf_phase_nco u_vf_phase_nco (
    .clk        (clk),
    .rst        (rst),
    .chan_start (chan_start),
    .cw_wr      (cw_wr),
    .cw_sel     (cw_sel),
    .cw_data    (cw_data),
    .vf_out     (vf_out),
    .vf_tick    (vf_tick)
  );

  function automatic logic [15:0] mag(input logic [15:0] w);
    if (w < 16'h8000) return w;
    return 16'(17'h10000 - {1'b0, w});
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input bit wr, input bit sel, input logic [7:0] d, input bit st);
    logic [15:0] nacc;
    cw_wr = wr; cw_sel = sel; cw_data = d; chan_start = st;
    @(posedge clk);
    nacc   = st ? m_acc + m_step : 16'h0;
    m_tick = st && !m_acc[15] && nacc[15];
    m_acc  = nacc;
    m_out  = nacc[15];
    m_step = mag(m_cw);
    if (wr) begin
      if (sel) m_cw[15:8] = d; else m_cw[7:0] = d;
    end
    @(negedge clk);
    check("R4 R10 vf_out", int'(vf_out), int'(m_out));
    check("R9 vf_tick", int'(vf_tick), int'(m_tick));
    tick_cnt += int'(vf_tick);
    high_cnt += int'(vf_out);
  endtask

  task automatic run(input int n, input bit st);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 8'h00, st);
  endtask

  task automatic load(input logic [15:0] w, input bit st);
    cyc(1'b1, 1'b1, w[15:8], st);
    cyc(1'b1, 1'b0, w[7:0], st);
    run(2, st);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; chan_start = 1'b0; cw_wr = 1'b0; cw_sel = 1'b0; cw_data = 8'h00;
    m_cw = 0; m_step = 0; m_acc = 0; m_out = 0; m_tick = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state at the ports
    check("R1 vf_out", int'(vf_out), 0);
    check("R1 vf_tick", int'(vf_tick), 0);
    // R1: stored word is zero, so running yields nothing
    tick_cnt = 0; high_cnt = 0;
    run(20, 1'b1);
    check("R1 ticks", tick_cnt, 0);

    // R8: zero word
    load(16'h0000, 1'b0);
    tick_cnt = 0; high_cnt = 0;
    run(100, 1'b1);
    check("R8 ticks", tick_cnt, 0);
    check("R8 high", high_cnt, 0);

    // R3: 0xC000 acts as 0x4000, period 4
    load(16'hC000, 1'b0);
    tick_cnt = 0; high_cnt = 0;
    run(64, 1'b1);
    check("R3 ticks", tick_cnt, 16);

    // R5: step 0x1000 is high exactly half the time
    load(16'h1000, 1'b0);
    tick_cnt = 0; high_cnt = 0;
    run(160, 1'b1);
    check("R5 high", high_cnt, 80);
    check("R5 ticks", tick_cnt, 10);

    // R7: restart from zero with step 0x4000
    load(16'h4000, 1'b0);
    cyc(1'b0, 1'b0, 8'h00, 1'b1);
    check("R7 first out", int'(vf_out), 0);
    check("R7 first tick", int'(vf_tick), 0);
    cyc(1'b0, 1'b0, 8'h00, 1'b1);
    check("R7 second out", int'(vf_out), 1);
    check("R7 second tick", int'(vf_tick), 1);
    run(9, 1'b1);

    // R6: start low holds zero
    tick_cnt = 0; high_cnt = 0;
    run(30, 1'b0);
    check("R6 high", high_cnt, 0);
    check("R6 ticks", tick_cnt, 0);

    // R2: high-byte write alone keeps low byte 0x00 -> 0x2000, period 8
    cyc(1'b1, 1'b1, 8'h20, 1'b0);
    run(2, 1'b0);
    tick_cnt = 0;
    run(64, 1'b1);
    check("R2 hi only ticks", tick_cnt, 8);
    // R2: low-byte write alone keeps high byte 0x20 -> 0x2080
    cyc(1'b1, 1'b0, 8'h80, 1'b0);
    run(2, 1'b0);
    tick_cnt = 0;
    run(64, 1'b1);
    check("R2 lo only ticks", tick_cnt, 8);

    // R10: mid-run rewrite tracked by the model each cycle
    load(16'h0800, 1'b1);
    cyc(1'b1, 1'b1, 8'h40, 1'b1);
    run(20, 1'b1);

    // Random phase: R3 R4 R9 R10 against the model
    for (int seg = 0; seg < 8; seg++) begin
      logic [15:0] w;
      int kind;
      kind = int'($urandom % 3);
      w = 16'($urandom);
      if (kind == 1) w = 16'h1 << ($urandom % 16);
      if (kind == 2) w[15] = 1'b1;
      load(w, 1'b1);
      for (int i = 0; i < 200; i++) begin
        int r;
        r = int'($urandom % 64);
        if (r == 0)      cyc(1'b0, 1'b0, 8'h00, 1'b0);
        else if (r == 1) cyc(1'b1, 1'($urandom % 2), 8'($urandom), 1'b1);
        else             cyc(1'b0, 1'b0, 8'h00, 1'b1);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule